// File: doc/BRIEF.md
# Performance Counter Global Control Unit

This block holds a bank of programmable event counters and a few fixed-function counters. All of them sit behind one global enable register and one 64-bit status word. Each counter counts the single-cycle increment pulses on its own event input. It counts only while three conditions hold together: its local enable bit is set, its bit in the global enable register is set, and the freeze flag in the status word is clear. When a counter wraps from all ones to zero, it records an overflow flag in the status word and the block pulses an interrupt. Single-bit pulses from neighbouring logic also set flags in the status word. These neighbours are the trace buffer, the secure-enclave monitor, the uncore, the debug-store buffer and a condition-change detector.

Software reaches the block through a plain register port. A write lands on the rising edge when `reg_we` is high. A read is combinational from `reg_addr`. The port has no back-pressure: every write completes in the cycle it is presented. No stream interface exists, so no valid/ready pair is used. Software cannot write the status word at its own address. It changes the word only through a write-one-to-set alias and a write-one-to-clear alias. Software normally writes the global enable register last, after it has configured the counters.

With freeze-on-interrupt mode on, any hardware overflow event also sets the counter-freeze and branch-record-freeze flags. All counting then stops until software clears the freeze flag.

Top module: `pmu_global_ctrl`

## Requirements
- R1: Programmable counter n (addresses 8+n, reading or loading the counter value) adds one per `prog_evt[n]` pulse only when local enable bit n (address 1), global bit n (address 0) and the inverse of status bit 58 are all 1. Otherwise it holds.
- R2: Fixed counter i (addresses 16+i) adds one per `fix_evt[i]` pulse only when fixed local enable bit i (address 2), global bit 32+i and the inverse of status bit 58 are all 1. Otherwise it holds.
- R3: A counter that increments from all ones (48 bits) reads zero on the next cycle. In that same cycle it sets status bit n (programmable) or bit 32+i (fixed), and `irq` is high for exactly one cycle.
- R4: With freeze-on-interrupt mode on (address 3, bit 0), every hardware overflow event also sets status bits 58 and 59 in the same cycle as the overflow bit. No counter changes while bit 58 is set. With the mode off, bits 58 and 59 stay clear.
- R5: A write to the status address (4) has no effect on the status word.
- R6: A write to address 5 sets the status bits that have a 1 in the write data. A write to address 6 clears them. Writes at reserved positions are ignored. The implemented bits are 0..3, 32..34, 55 and 58..63, mask 0xFC80_0007_0000_000F. Reserved bits and the two aliases always read zero.
- R7: When a hardware set event and a clear-alias write hit the same bit in one cycle, the bit ends up set.
- R8: A trace-buffer-full pulse sets bit 55, an uncore overflow pulse sets bit 61 and a debug-store overflow pulse sets bit 62. Each of these also raises `irq` for one cycle. A condition-change pulse sets bit 63 without raising `irq`.
- R9: A secure-activity pulse sets bit 60 only if at least one counter is effectively enabled in that cycle. The bit stays set until software clears it.
- R10: A software write to a counter in the same cycle as an increment pulse leaves the written value.
- R11: After reset, all counters, enables, mode and status read zero and `irq` is low.
- R12: Global enable (address 0) reads back only bits 0..3 and 32..34. Local enable registers keep only their low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational |
| prog_evt | input | 4 | Increment pulses, one per programmable counter |
| fix_evt | input | 3 | Increment pulses, one per fixed counter |
| trace_full_evt | input | 1 | Trace output buffer filled |
| secure_evt | input | 1 | Secure-enclave activity |
| uncore_ovf_evt | input | 1 | Uncore counter overflow |
| dsbuf_ovf_evt | input | 1 | Debug-store buffer overflow |
| cond_chg_evt | input | 1 | Monitoring condition changed |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situations to reach are the same-cycle collisions: a counter wrap arriving together with a clear of its own overflow bit, an increment together with a load, and a freeze raised while other counters still have events pending. The stimulus preloads counters to all ones through the register port, so that a single pulse forces a wrap. It then issues the colliding write in exactly the cycle of that pulse. A sweep over every combination of local enable, global enable and freeze for every counter covers the three-way gate.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int STS_W      = 64;
  localparam int FIX_BASE   = 32;
  localparam int BIT_TRACE  = 55;
  localparam int BIT_CFRZ   = 58;
  localparam int BIT_BFRZ   = 59;
  localparam int BIT_SECURE = 60;
  localparam int BIT_UNC    = 61;
  localparam int BIT_DS     = 62;
  localparam int BIT_COND   = 63;

  localparam int ADR_GLOBAL = 0;
  localparam int ADR_PLOCAL = 1;
  localparam int ADR_FLOCAL = 2;
  localparam int ADR_MODE   = 3;
  localparam int ADR_STATUS = 4;
  localparam int ADR_SET    = 5;
  localparam int ADR_CLR    = 6;
  localparam int ADR_PROG0  = 8;
  localparam int ADR_FIX0   = 16;

  function automatic logic [STS_W-1:0] cnt_mask(input int np, input int nf);
    logic [STS_W-1:0] m;
    m = '0;
    for (int i = 0; i < np; i++) m[i] = 1'b1;
    for (int i = 0; i < nf; i++) m[FIX_BASE+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [STS_W-1:0] impl_mask(input int np, input int nf);
    logic [STS_W-1:0] m;
    m = cnt_mask(np, nf);
    m[BIT_TRACE] = 1'b1;
    for (int b = BIT_CFRZ; b <= BIT_COND; b++) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [STS_W-1:0] irq_mask(input int np, input int nf);
    logic [STS_W-1:0] m;
    m = cnt_mask(np, nf);
    m[BIT_TRACE] = 1'b1;
    m[BIT_UNC]   = 1'b1;
    m[BIT_DS]    = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         evt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic bump;
  assign bump = cnt_en && evt && !ld;
  assign wrap = bump && (&value);

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (ld)   value <= ld_val;
    else if (bump) value <= value + 1'b1;
  end

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(cnt_en && evt)) |=> $stable(value)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (value == $past(ld_val))); // R10
endmodule

// File: rtl/pmu_status.sv
module pmu_status import pmu_pkg::*; #(
  parameter int NUM_PROG = 4,
  parameter int NUM_FIX  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frz_mode,
  input  logic [STS_W-1:0] hw_set,
  input  logic [STS_W-1:0] sw_set,
  input  logic [STS_W-1:0] sw_clr,
  output logic [STS_W-1:0] status,
  output logic             irq
);
  localparam logic [STS_W-1:0] IMPL = impl_mask(NUM_PROG, NUM_FIX);
  localparam logic [STS_W-1:0] IRQM = irq_mask(NUM_PROG, NUM_FIX);

  logic             irq_evt;
  logic [STS_W-1:0] hw_all;
  logic [STS_W-1:0] nxt;

  always_comb begin
    irq_evt = |(hw_set & IRQM);
    hw_all  = hw_set;
    if (frz_mode && irq_evt) begin
      hw_all[BIT_CFRZ] = 1'b1;
      hw_all[BIT_BFRZ] = 1'b1;
    end
    nxt = ((status & ~sw_clr) | sw_set | hw_all) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= irq_evt;
    end
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_set & IMPL) != '0) |=> ((status & $past(hw_set & IMPL)) == $past(hw_set & IMPL))); // R7
  AST_FRZ_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_mode && ((hw_set & IRQM) != '0)) |=> (status[BIT_CFRZ] && status[BIT_BFRZ])); // R4
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & IRQM) != '0)); // R3
endmodule

// File: rtl/pmu_global_ctrl.sv
module pmu_global_ctrl import pmu_pkg::*; #(
  parameter int NUM_PROG = 4,
  parameter int NUM_FIX  = 3,
  parameter int CNT_W    = 48,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [STS_W-1:0]    reg_wdata,
  output logic [STS_W-1:0]    reg_rdata,
  input  logic [NUM_PROG-1:0] prog_evt,
  input  logic [NUM_FIX-1:0]  fix_evt,
  input  logic                trace_full_evt,
  input  logic                secure_evt,
  input  logic                uncore_ovf_evt,
  input  logic                dsbuf_ovf_evt,
  input  logic                cond_chg_evt,
  output logic                irq
);
  localparam logic [STS_W-1:0] GLB_MASK = cnt_mask(NUM_PROG, NUM_FIX);

  logic [STS_W-1:0]    glb_q;
  logic [NUM_PROG-1:0] ple_q;
  logic [NUM_FIX-1:0]  fle_q;
  logic                frz_mode_q;
  logic [STS_W-1:0]    status;
  logic                frozen;

  logic [NUM_PROG-1:0] peff, pld, pwrap;
  logic [NUM_FIX-1:0]  feff, fld, fwrap;
  logic [CNT_W-1:0]    pcnt [NUM_PROG];
  logic [CNT_W-1:0]    fcnt [NUM_FIX];

  logic             any_active;
  logic [STS_W-1:0] hw_set, sw_set, sw_clr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  assign frozen = status[BIT_CFRZ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_q      <= '0;
      ple_q      <= '0;
      fle_q      <= '0;
      frz_mode_q <= 1'b0;
    end else if (reg_we) begin
      if (hit(reg_addr, ADR_GLOBAL)) glb_q      <= reg_wdata & GLB_MASK;
      if (hit(reg_addr, ADR_PLOCAL)) ple_q      <= reg_wdata[NUM_PROG-1:0];
      if (hit(reg_addr, ADR_FLOCAL)) fle_q      <= reg_wdata[NUM_FIX-1:0];
      if (hit(reg_addr, ADR_MODE))   frz_mode_q <= reg_wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
    assign peff[i] = ple_q[i] && glb_q[i] && !frozen;
    assign pld[i]  = reg_we && hit(reg_addr, ADR_PROG0 + i);
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_en(peff[i]), .evt(prog_evt[i]),
      .ld(pld[i]), .ld_val(reg_wdata[CNT_W-1:0]), .value(pcnt[i]), .wrap(pwrap[i])
    );
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !pld[i]) |=> $stable(pcnt[i])); // R4
  end

  for (genvar i = 0; i < NUM_FIX; i++) begin : g_fix
    assign feff[i] = fle_q[i] && glb_q[FIX_BASE+i] && !frozen;
    assign fld[i]  = reg_we && hit(reg_addr, ADR_FIX0 + i);
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_en(feff[i]), .evt(fix_evt[i]),
      .ld(fld[i]), .ld_val(reg_wdata[CNT_W-1:0]), .value(fcnt[i]), .wrap(fwrap[i])
    );
    AST_FIX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!fld[i] && !(fle_q[i] && glb_q[FIX_BASE+i] && !frozen && fix_evt[i])) |=> $stable(fcnt[i])); // R2
  end

  assign any_active = (|peff) || (|feff);

  always_comb begin
    hw_set = '0;
    hw_set[NUM_PROG-1:0]          = pwrap;
    hw_set[FIX_BASE +: NUM_FIX]   = fwrap;
    hw_set[BIT_TRACE]             = trace_full_evt;
    hw_set[BIT_SECURE]            = secure_evt && any_active;
    hw_set[BIT_UNC]               = uncore_ovf_evt;
    hw_set[BIT_DS]                = dsbuf_ovf_evt;
    hw_set[BIT_COND]              = cond_chg_evt;
    sw_set = (reg_we && hit(reg_addr, ADR_SET)) ? reg_wdata : '0;
    sw_clr = (reg_we && hit(reg_addr, ADR_CLR)) ? reg_wdata : '0;
  end

  pmu_status #(.NUM_PROG(NUM_PROG), .NUM_FIX(NUM_FIX)) u_status (
    .clk(clk), .rst_n(rst_n), .frz_mode(frz_mode_q), .hw_set(hw_set),
    .sw_set(sw_set), .sw_clr(sw_clr), .status(status), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, ADR_GLOBAL)) reg_rdata = glb_q;
    if (hit(reg_addr, ADR_PLOCAL)) reg_rdata = STS_W'(ple_q);
    if (hit(reg_addr, ADR_FLOCAL)) reg_rdata = STS_W'(fle_q);
    if (hit(reg_addr, ADR_MODE))   reg_rdata = STS_W'(frz_mode_q);
    if (hit(reg_addr, ADR_STATUS)) reg_rdata = status;
    for (int i = 0; i < NUM_PROG; i++)
      if (hit(reg_addr, ADR_PROG0 + i)) reg_rdata = STS_W'(pcnt[i]);
    for (int i = 0; i < NUM_FIX; i++)
      if (hit(reg_addr, ADR_FIX0 + i)) reg_rdata = STS_W'(fcnt[i]);
  end

  AST_SECURE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[BIT_SECURE] && !any_active && !(reg_we && hit(reg_addr, ADR_SET))) |=> !status[BIT_SECURE]); // R9
endmodule

// File: tb/pmu_global_ctrl_tb_top.sv
`timescale 1ns/1ps
module pmu_global_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [3:0]  prog_evt = '0;
  logic [2:0]  fix_evt = '0;
  logic        trace_full_evt = 1'b0, secure_evt = 1'b0, uncore_ovf_evt = 1'b0;
  logic        dsbuf_ovf_evt = 1'b0, cond_chg_evt = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [63:0] ALL   = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] IMPL  = 64'hFC80_0007_0000_000F;
  localparam logic [63:0] GLBM  = 64'h0000_0007_0000_000F;
  localparam logic [63:0] TOP48 = 64'h0000_FFFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  pmu_global_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prog_evt(prog_evt),
    .fix_evt(fix_evt), .trace_full_evt(trace_full_evt), .secure_evt(secure_evt),
    .uncore_ovf_evt(uncore_ovf_evt), .dsbuf_ovf_evt(dsbuf_ovf_evt),
    .cond_chg_evt(cond_chg_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // side = {cond, dsbuf, uncore, secure, trace}
  task automatic step(input logic we, input logic [4:0] a, input logic [63:0] d,
                      input logic [3:0] pv, input logic [2:0] fv, input logic [4:0] side);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; prog_evt = pv; fix_evt = fv;
    {cond_chg_evt, dsbuf_ovf_evt, uncore_ovf_evt, secure_evt, trace_full_evt} = side;
    @(negedge clk);
    reg_we = 1'b0; prog_evt = '0; fix_evt = '0;
    {cond_chg_evt, dsbuf_ovf_evt, uncore_ovf_evt, secure_evt, trace_full_evt} = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    step(1'b1, a, d, 4'h0, 3'h0, 5'h0);
  endtask

  task automatic rd(input logic [4:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(4, v); chk("R11 status", v, 64'h0);
    rd(8, v); chk("R11 counter", v, 64'h0);
    rd(0, v); chk("R11 global", v, 64'h0);
    chk("R11 irq", {63'h0, irq}, 64'h0);

    // R1 sweep: local enable m[0], global m[1], freeze m[2]
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 8; m++) begin
        wr(6, ALL);
        wr(1, m[0] ? (64'd1 << c) : 64'd0);
        wr(0, m[1] ? (64'd1 << c) : 64'd0);
        if (m[2]) wr(5, 64'd1 << 58);
        wr(5'(8 + c), 64'd0);
        repeat (3) step(1'b0, 5'd0, 64'd0, 4'hF, 3'h0, 5'h0);
        rd(5'(8 + c), v);
        chk("R1 gate", v, (m == 3) ? 64'd3 : 64'd0);
      end
    end
    // R2 sweep
    for (int c = 0; c < 3; c++) begin
      for (int m = 0; m < 8; m++) begin
        wr(6, ALL);
        wr(2, m[0] ? (64'd1 << c) : 64'd0);
        wr(0, m[1] ? (64'd1 << (32 + c)) : 64'd0);
        if (m[2]) wr(5, 64'd1 << 58);
        wr(5'(16 + c), 64'd0);
        repeat (3) step(1'b0, 5'd0, 64'd0, 4'h0, 3'h7, 5'h0);
        rd(5'(16 + c), v);
        chk("R2 gate", v, (m == 3) ? 64'd3 : 64'd0);
      end
    end

    // R12 readback masks
    wr(0, ALL); rd(0, v); chk("R12 global", v, GLBM);
    wr(1, ALL); rd(1, v); chk("R12 plocal", v, 64'hF);
    wr(2, ALL); rd(2, v); chk("R12 flocal", v, 64'h7);
    wr(6, ALL);

    // R3 wrap, overflow bit, one-cycle irq (mode off)
    for (int c = 0; c < 4; c++) begin
      wr(5'(8 + c), TOP48);
      step(1'b0, 5'd0, 64'd0, 4'(1 << c), 3'h0, 5'h0);
      chk("R3 irq high", {63'h0, irq}, 64'd1);
      rd(4, v); chk("R3 prog status", v, 64'd1 << c);
      rd(5'(8 + c), v); chk("R3 prog wrap", v, 64'd0);
      @(negedge clk);
      chk("R3 irq low", {63'h0, irq}, 64'd0);
      wr(6, ALL);
    end
    for (int c = 0; c < 3; c++) begin
      wr(5'(16 + c), TOP48);
      step(1'b0, 5'd0, 64'd0, 4'h0, 3'(1 << c), 5'h0);
      chk("R3 irq high", {63'h0, irq}, 64'd1);
      rd(4, v); chk("R3 fix status", v, 64'd1 << (32 + c));
      rd(5'(16 + c), v); chk("R3 fix wrap", v, 64'd0);
      wr(6, ALL);
    end

    // R4 freeze on interrupt
    wr(3, 64'd1);
    wr(16, TOP48);
    wr(8, 64'd5);
    step(1'b0, 5'd0, 64'd0, 4'h0, 3'h1, 5'h0);
    rd(4, v); chk("R4 freeze set", v, (64'd1 << 32) | (64'd1 << 58) | (64'd1 << 59));
    step(1'b0, 5'd0, 64'd0, 4'h1, 3'h1, 5'h0);
    rd(8, v);  chk("R4 frozen prog", v, 64'd5);
    rd(16, v); chk("R4 frozen fix", v, 64'd0);
    wr(6, 64'd1 << 58);
    step(1'b0, 5'd0, 64'd0, 4'h1, 3'h0, 5'h0);
    rd(8, v); chk("R4 resume", v, 64'd6);
    wr(3, 64'd0);
    wr(6, ALL);

    // R5 status address is read-only
    wr(4, ALL); rd(4, v); chk("R5 ro", v, 64'd0);
    // R6 set/clear aliases
    wr(5, ALL); rd(4, v); chk("R6 set mask", v, IMPL);
    rd(5, v); chk("R6 set alias reads 0", v, 64'd0);
    rd(6, v); chk("R6 clr alias reads 0", v, 64'd0);
    wr(6, 64'd5); rd(4, v); chk("R6 clear", v, IMPL & ~64'd5);
    wr(6, ALL); rd(4, v); chk("R6 clear all", v, 64'd0);

    // R7 hardware set beats clear
    wr(9, TOP48);
    step(1'b1, 5'd6, 64'd2, 4'h2, 3'h0, 5'h0);
    rd(4, v); chk("R7 wrap vs clr", v, 64'd2);
    wr(6, ALL);
    step(1'b1, 5'd6, 64'd1 << 55, 4'h0, 3'h0, 5'h01);
    rd(4, v); chk("R7 trace vs clr", v, 64'd1 << 55);
    wr(6, ALL);

    // R8 side-band flags
    step(1'b0, 5'd0, 64'd0, 4'h0, 3'h0, 5'h01);
    chk("R8 trace irq", {63'h0, irq}, 64'd1);
    rd(4, v); chk("R8 trace bit", v, 64'd1 << 55); wr(6, ALL);
    step(1'b0, 5'd0, 64'd0, 4'h0, 3'h0, 5'h04);
    chk("R8 uncore irq", {63'h0, irq}, 64'd1);
    rd(4, v); chk("R8 uncore bit", v, 64'd1 << 61); wr(6, ALL);
    step(1'b0, 5'd0, 64'd0, 4'h0, 3'h0, 5'h08);
    chk("R8 ds irq", {63'h0, irq}, 64'd1);
    rd(4, v); chk("R8 ds bit", v, 64'd1 << 62); wr(6, ALL);
    step(1'b0, 5'd0, 64'd0, 4'h0, 3'h0, 5'h10);
    chk("R8 cond no irq", {63'h0, irq}, 64'd0);
    rd(4, v); chk("R8 cond bit", v, 64'd1 << 63); wr(6, ALL);

    // R9 secure indicator
    wr(0, 64'd0);
    step(1'b0, 5'd0, 64'd0, 4'h0, 3'h0, 5'h02);
    rd(4, v); chk("R9 idle ignored", v, 64'd0);
    wr(0, 64'd1);
    step(1'b0, 5'd0, 64'd0, 4'h0, 3'h0, 5'h02);
    rd(4, v); chk("R9 set", v, 64'd1 << 60);
    repeat (5) @(negedge clk);
    rd(4, v); chk("R9 sticky", v, 64'd1 << 60);
    wr(6, ALL); rd(4, v); chk("R9 cleared", v, 64'd0);

    // R10 load beats increment
    wr(8, 64'd10);
    step(1'b1, 5'd8, 64'd100, 4'h1, 3'h0, 5'h0);
    rd(8, v); chk("R10 load wins", v, 64'd100);
    step(1'b0, 5'd0, 64'd0, 4'h1, 3'h0, 5'h0);
    rd(8, v); chk("R10 then count", v, 64'd101);

    finish_run();
  end
endmodule